// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the byte mailbox between a system bus and an embedded keyboard-controller CPU. The host pushes bytes into a one-byte input register. Each host write is tagged as a command or as data by a single address-select input. The CPU answers by loading a one-byte output register, which the host then collects. A status byte carries the two buffer-full flags and the command/data tag. Both sides see this byte, and the host has no path that writes it.

Two interrupt lines come out of the block, one for the keyboard and one for the auxiliary (mouse) device. After reset each line is a plain output that follows a port bit the CPU writes. Once the CPU issues its one-time flag-enable strobe, the port bits become gates instead. The keyboard line then carries the output-buffer-full flag, and the mouse line carries the inverted input-buffer-full flag, so it signals that the CPU has taken the last host byte. All state is registered, so every port effect shows one clock after the request.

Top module: `kbc_mailbox`

## Requirements
- R1: A host write (`host_wr_en`) stores `host_wr_data` in the input register, which `cpu_rd_data` shows, and sets the input-full flag (status bit 1) on the next clock.
- R2: Status bit 3 takes the value of `host_wr_cmd` from the last host write (1 = command, 0 = data). Status bit 0 is output-full, bit 1 is input-full, and bits 2 and 7:4 always read 0.
- R3: A CPU write (`cpu_wr_en`) stores `cpu_wr_data` in the output register, which `host_rd_data` shows, and sets output-full (status bit 0).
- R4: `cpu_rd_en` clears input-full and `host_rd_en` clears output-full. When a flag is set and cleared in the same cycle, the set wins.
- R5: With flag gating on, `kbd_irq` equals output-full while the keyboard port bit is 1, and is 0 while that bit is 0.
- R6: With flag gating on, `aux_irq` equals the inverse of input-full while the mouse port bit is 1, and is 0 while that bit is 0.
- R7: With flag gating off, `kbd_irq` and `aux_irq` equal the keyboard and mouse port bits last loaded by `cpu_port_wr`, whatever the flags are.
- R8: Flag gating turns on with a `cpu_gate_en` pulse and stays on until reset. Further pulses change nothing.
- R9: Reset clears both flags, the tag, both port bits and the gating mode. The status byte, `kbd_irq` and `aux_irq` are then 0.
- R10: A host write while input-full is set replaces the stored byte and the tag, and input-full stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe to the input register |
| host_wr_cmd | input | 1 | Address select for the host write: 1 = command, 0 = data |
| host_wr_data | input | DATA_W | Host write byte |
| host_rd_en | input | 1 | Host read strobe for the output register |
| host_rd_data | output | DATA_W | Output register contents |
| status | output | 8 | Status byte (bit 0 output-full, bit 1 input-full, bit 3 command tag) |
| cpu_wr_en | input | 1 | CPU write strobe to the output register |
| cpu_wr_data | input | DATA_W | CPU write byte |
| cpu_rd_en | input | 1 | CPU read strobe for the input register |
| cpu_rd_data | output | DATA_W | Input register contents |
| cpu_gate_en | input | 1 | One-time flag-gating enable strobe |
| cpu_port_wr | input | 1 | Load strobe for the two port bits |
| cpu_port_kb | input | 1 | Keyboard port bit value |
| cpu_port_ms | input | 1 | Mouse port bit value |
| kbd_irq | output | 1 | Keyboard interrupt |
| aux_irq | output | 1 | Mouse interrupt |

## Verification
The bench targets the same-cycle collisions of a set and a clear on each flag. A design that let the clear win would drop a freshly written byte and lose an interrupt. It also writes twice into a full input register, which catches a design that loses the new byte or the command tag, or that toggles the flag. Mode handling is checked by raising a port bit while the related flag sits idle: a design that never gates would raise the interrupt, and one that let a second enable pulse or a port write undo the mode would fall back to direct control. A reset in the middle of the run confirms that gating and the port bits return to their direct, low state.

// File: rtl/kbc_mbox_pkg.sv
package kbc_mbox_pkg;
  localparam int STAT_W   = 8;
  localparam int STAT_OBF = 0;
  localparam int STAT_IBF = 1;
  localparam int STAT_CMD = 3;
  localparam int IRQ_N    = 2;
  localparam int IRQ_KBD  = 0;
  localparam int IRQ_AUX  = 1;
endpackage

// File: rtl/kbc_inbuf.sv
module kbc_inbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_cmd,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] data_q,
  output logic          full_q,
  output logic          cmd_q
);
  logic full_d;

  // set beats clear when both land in one cycle
  always_comb begin
    full_d = full_q;
    if (rd_en) full_d = 1'b0;
    if (wr_en) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cmd_q  <= 1'b0;
    end else if (wr_en) begin
      data_q <= wr_data;
      cmd_q  <= wr_cmd;
    end
  end
endmodule

// File: rtl/kbc_outbuf.sv
module kbc_outbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] data_q,
  output logic          full_q
);
  logic full_d;

  always_comb begin
    full_d = full_q;
    if (rd_en) full_d = 1'b0;
    if (wr_en) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (wr_en) begin
      data_q <= wr_data;
    end
  end
endmodule

// File: rtl/kbc_irq_gate.sv
module kbc_irq_gate #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate_set,
  input  logic         port_wr,
  input  logic [N-1:0] port_val,
  input  logic [N-1:0] flag_src,
  output logic [N-1:0] irq
);
  logic         gate_q, gate_d;
  logic [N-1:0] port_q;

  // sticky: only reset can clear the gating mode
  always_comb begin
    gate_d = gate_q | gate_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
    end else if (port_wr) begin
      port_q <= port_val;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    always_comb begin
      if (gate_q) irq[g] = port_q[g] & flag_src[g];
      else        irq[g] = port_q[g];
    end
  end
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
  import kbc_mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_wr_cmd,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              host_rd_en,
  output logic [DATA_W-1:0] host_rd_data,
  output logic [STAT_W-1:0] status,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic              cpu_rd_en,
  output logic [DATA_W-1:0] cpu_rd_data,
  input  logic              cpu_gate_en,
  input  logic              cpu_port_wr,
  input  logic              cpu_port_kb,
  input  logic              cpu_port_ms,
  output logic              kbd_irq,
  output logic              aux_irq
);
  logic             ibf, obf, cmd_tag;
  logic [IRQ_N-1:0] port_val, flag_src, irq_vec;

  kbc_inbuf #(.DW(DATA_W)) u_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (host_wr_en),
    .wr_cmd  (host_wr_cmd),
    .wr_data (host_wr_data),
    .rd_en   (cpu_rd_en),
    .data_q  (cpu_rd_data),
    .full_q  (ibf),
    .cmd_q   (cmd_tag)
  );

  kbc_outbuf #(.DW(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cpu_wr_en),
    .wr_data (cpu_wr_data),
    .rd_en   (host_rd_en),
    .data_q  (host_rd_data),
    .full_q  (obf)
  );

  always_comb begin
    port_val           = '0;
    flag_src           = '0;
    port_val[IRQ_KBD]  = cpu_port_kb;
    port_val[IRQ_AUX]  = cpu_port_ms;
    flag_src[IRQ_KBD]  = obf;
    flag_src[IRQ_AUX]  = ~ibf;
  end

  kbc_irq_gate #(.N(IRQ_N)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_set (cpu_gate_en),
    .port_wr  (cpu_port_wr),
    .port_val (port_val),
    .flag_src (flag_src),
    .irq      (irq_vec)
  );

  assign kbd_irq = irq_vec[IRQ_KBD];
  assign aux_irq = irq_vec[IRQ_AUX];

  always_comb begin
    status           = '0;
    status[STAT_OBF] = obf;
    status[STAT_IBF] = ibf;
    status[STAT_CMD] = cmd_tag;
  end
endmodule

// File: rtl/kbc_mailbox_chk.sv
module kbc_mailbox_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr_en,
  input logic          host_wr_cmd,
  input logic [DW-1:0] host_wr_data,
  input logic          host_rd_en,
  input logic [DW-1:0] host_rd_data,
  input logic          cpu_wr_en,
  input logic [DW-1:0] cpu_wr_data,
  input logic          cpu_rd_en,
  input logic [DW-1:0] cpu_rd_data,
  input logic          st_obf,
  input logic          st_ibf,
  input logic          st_cmd,
  input logic          kbd_irq,
  input logic          aux_irq
);
  // R1
  a_r1_ibf_set: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_en |=> st_ibf && (cpu_rd_data == $past(host_wr_data)));
  // R2
  a_r2_cmd_tag: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_en |=> st_cmd == $past(host_wr_cmd));
  // R3
  a_r3_obf_set: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_en |=> st_obf && (host_rd_data == $past(cpu_wr_data)));
  // R4
  a_r4_ibf_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd_en && !host_wr_en) |=> !st_ibf);
  // R4
  a_r4_obf_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && !cpu_wr_en) |=> !st_obf);
  // R9
  a_r9_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !kbd_irq && !aux_irq && !st_obf && !st_ibf && !st_cmd);
endmodule

bind kbc_mailbox kbc_mailbox_chk #(.DW(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_wr_en   (host_wr_en),
  .host_wr_cmd  (host_wr_cmd),
  .host_wr_data (host_wr_data),
  .host_rd_en   (host_rd_en),
  .host_rd_data (host_rd_data),
  .cpu_wr_en    (cpu_wr_en),
  .cpu_wr_data  (cpu_wr_data),
  .cpu_rd_en    (cpu_rd_en),
  .cpu_rd_data  (cpu_rd_data),
  .st_obf       (status[0]),
  .st_ibf       (status[1]),
  .st_cmd       (status[3]),
  .kbd_irq      (kbd_irq),
  .aux_irq      (aux_irq)
);

// File: tb/kbc_mailbox_test.sv
`timescale 1ns/1ps
module kbc_mailbox_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_wr_en, host_wr_cmd, host_rd_en;
  logic [7:0] host_wr_data, host_rd_data, status;
  logic       cpu_wr_en, cpu_rd_en, cpu_gate_en, cpu_port_wr, cpu_port_kb, cpu_port_ms;
  logic [7:0] cpu_wr_data, cpu_rd_data;
  logic       kbd_irq, aux_irq;
  int         n_chk = 0, n_bad = 0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  kbc_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_cmd(host_wr_cmd), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_data(host_rd_data), .status(status),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .cpu_rd_en(cpu_rd_en),
    .cpu_rd_data(cpu_rd_data), .cpu_gate_en(cpu_gate_en), .cpu_port_wr(cpu_port_wr),
    .cpu_port_kb(cpu_port_kb), .cpu_port_ms(cpu_port_ms),
    .kbd_irq(kbd_irq), .aux_irq(aux_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    host_wr_en = 0; host_wr_cmd = 0; host_wr_data = 0; host_rd_en = 0;
    cpu_wr_en = 0; cpu_wr_data = 0; cpu_rd_en = 0; cpu_gate_en = 0;
    cpu_port_wr = 0; cpu_port_kb = 0; cpu_port_ms = 0;
  endtask

  // inputs were set at a falling edge; let one rising edge pass, then clear
  task automatic tick();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 status", status, 8'h00);
    chk("R9 kbd_irq", {7'd0, kbd_irq}, 8'h00);
    chk("R9 aux_irq", {7'd0, aux_irq}, 8'h00);
  endtask

  task automatic t_host_write();
    host_wr_en = 1; host_wr_cmd = 0; host_wr_data = 8'h5A; tick();
    chk("R1 data byte", cpu_rd_data, 8'h5A);
    chk("R1/R2 status data write", status, 8'h02);
    host_wr_en = 1; host_wr_cmd = 1; host_wr_data = 8'hD1; tick();
    chk("R10 overwrite byte", cpu_rd_data, 8'hD1);
    chk("R10/R2 status cmd overwrite", status, 8'h0A);
    cpu_rd_en = 1; tick();
    chk("R4 cpu read clears ibf", status, 8'h08);
  endtask

  task automatic t_cpu_write();
    cpu_wr_en = 1; cpu_wr_data = 8'h3C; tick();
    chk("R3 out byte", host_rd_data, 8'h3C);
    chk("R3 status obf", status, 8'h09);
    host_rd_en = 1; tick();
    chk("R4 host read clears obf", status, 8'h08);
  endtask

  task automatic t_collide();
    host_wr_en = 1; host_wr_data = 8'h11; tick();
    host_wr_en = 1; host_wr_data = 8'h22; cpu_rd_en = 1; tick();
    chk("R4 ibf set wins", status, 8'h02);
    chk("R4 byte on collide", cpu_rd_data, 8'h22);
    cpu_wr_en = 1; cpu_wr_data = 8'h44; tick();
    cpu_wr_en = 1; cpu_wr_data = 8'h55; host_rd_en = 1; tick();
    chk("R4 obf set wins", status, 8'h03);
    chk("R3 byte on collide", host_rd_data, 8'h55);
    cpu_rd_en = 1; host_rd_en = 1; tick();
    chk("R4 both cleared", status, 8'h00);
  endtask

  task automatic t_direct();
    cpu_port_wr = 1; cpu_port_kb = 1; cpu_port_ms = 0; tick();
    chk("R7 kbd follows port", {6'd0, aux_irq, kbd_irq}, 8'h01);
    cpu_port_wr = 1; cpu_port_kb = 0; cpu_port_ms = 1; tick();
    chk("R7 aux follows port", {6'd0, aux_irq, kbd_irq}, 8'h02);
    host_wr_en = 1; host_wr_data = 8'h01; tick();
    chk("R7 aux ignores ibf", {6'd0, aux_irq, kbd_irq}, 8'h02);
    cpu_rd_en = 1; tick();
  endtask

  task automatic t_gated();
    cpu_gate_en = 1; cpu_port_wr = 1; cpu_port_kb = 1; cpu_port_ms = 1; tick();
    chk("R5/R6 gated idle flags", {6'd0, aux_irq, kbd_irq}, 8'h02);
    cpu_wr_en = 1; cpu_wr_data = 8'h77; tick();
    chk("R5 kbd shows obf", {7'd0, kbd_irq}, 8'h01);
    host_wr_en = 1; host_wr_data = 8'h88; tick();
    chk("R6 aux shows not ibf", {7'd0, aux_irq}, 8'h00);
    cpu_port_wr = 1; cpu_port_kb = 0; cpu_port_ms = 0; tick();
    cpu_rd_en = 1; tick();
    chk("R5/R6 forced low with port 0", {6'd0, aux_irq, kbd_irq}, 8'h00);
  endtask

  task automatic t_sticky();
    cpu_gate_en = 1; tick();
    cpu_port_wr = 1; cpu_port_kb = 1; host_rd_en = 1; tick();
    chk("R8 still gated", {7'd0, kbd_irq}, 8'h00);
    do_reset();
    chk("R9 status after mid reset", status, 8'h00);
    cpu_port_wr = 1; cpu_port_kb = 1; tick();
    chk("R8/R9 reset restores direct", {7'd0, kbd_irq}, 8'h01);
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    do_reset();
    t_reset();
    t_host_write();
    t_cpu_write();
    t_collide();
    t_direct();
    t_gated();
    t_sticky();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule